// File: doc/BRIEF.md
# Write-Update Coherent Cache Controller

This controller sits between one processor and a directory-based shared memory that keeps caches coherent by pushing new data to them, not by invalidating them. It holds a small direct-mapped array of lines. Each line is in one of three states: nothing, shared, or transient (a fill is pending). Loads that hit are served locally. Loads that miss send a share request to the home node and wait for the line. Stores are write-through and never allocate a line: each one sends a single-word write request to the home node. The processor stalls on a store only when it already holds the line. In that case the cached word changes only when the home node's write reply returns with the data.

Update messages from the home node overwrite one word of a shared line. When a line is held, they leave its state as it is. When a load misses on an index that holds another tag, the old line is replaced without any message to the home node. Only one request is outstanding at a time. The processor side uses a valid/ready handshake, and outgoing requests are held until the network accepts them. Incoming messages are always accepted.

Addresses split into a word offset in the low OFF_W bits, a line index in the next IDX_W bits, and a tag in the remaining upper bits. Incoming messages are coded on `rsp_kind` as 0 = share reply (full line on `rsp_line`, word w at bits [w*DW +: DW]), 1 = write reply (one word on `rsp_word`) and 2 = update (one word on `rsp_word`). On `req_write`, 0 marks a share request and 1 marks a write request.

Top module: `wu_cache_ctrl`

## Requirements
- R1: After reset every line is in the nothing state, `cpu_ready` is 1, and `req_valid` and `cpu_rvalid` are 0.
- R2: A store to a line held in the shared state sends a write request (`req_write`=1) with its address and word. `cpu_ready` then stays 0 until a write reply arrives. The reply's word is written into the line, and `cpu_ready` is 1 in the cycle after the reply.
- R3: A store to a line that is not held sends a write request and allocates nothing. `cpu_ready` is 1 in the cycle after the request handshake, and a later load of that address misses.
- R4: A load that misses sets the line to transient, sends a share request (`req_write`=0) carrying the load address, and holds `cpu_ready` at 0 until the share reply.
- R5: A load that hits a shared line returns the cached word with `cpu_rvalid`=1 in the cycle after acceptance, sends no request and changes no state.
- R6: A share reply received while a fill is pending writes the whole line, makes it shared, and returns the addressed word with `cpu_rvalid`=1 and `cpu_ready`=1 in the next cycle.
- R7: A miss on an index that holds another tag replaces that line silently: the only message sent is the new share request, and a later load of the old address misses again.
- R8: An update overwrites the addressed word of a shared line with a matching tag. An update is ignored for a line that is not held or that is transient.
- R9: A write reply that arrives while no store is waiting updates the word of a held line in the same way as an update, and leaves `cpu_ready` at 1.
- R10: At most one request is outstanding. `cpu_ready` is 0 while a request is pending, and `req_valid`, `req_write`, `req_addr` and `req_data` hold steady until `req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Controller accepts a processor request (0 = stall) |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DW | Store data |
| cpu_rvalid | output | 1 | Load data valid, one cycle |
| cpu_rdata | output | DW | Load data |
| req_valid | output | 1 | Outgoing request pending |
| req_ready | input | 1 | Network takes the request |
| req_write | output | 1 | 1 = write request, 0 = share request |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DW | Store word for a write request, 0 otherwise |
| rsp_valid | input | 1 | Incoming message present |
| rsp_kind | input | 2 | 0 share reply, 1 write reply, 2 update |
| rsp_addr | input | ADDR_W | Message address |
| rsp_word | input | DW | Word for a write reply or update |
| rsp_line | input | DW*2**OFF_W | Line data for a share reply |

## Verification
A processor request is registered on the edge where it is taken. A hit's data, or the outgoing request of a miss or store, therefore appears in the cycle after acceptance, and the bench samples there at the falling edge. The release of a stall shows in the cycle after the edge that consumes the request handshake (absent-line store), the write reply (present-line store) or the share reply (load miss), and each of these is sampled in that cycle. Between those edges the bench samples that `cpu_ready` stays low and the request stays stable. Updates and stray replies change only the array, so their effect is sampled through the next load of the touched address.

// File: rtl/wu_cache_ctrl.sv
module wu_cache_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DW     = 16,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_valid,
  output logic                      cpu_ready,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [DW-1:0]             cpu_wdata,
  output logic                      cpu_rvalid,
  output logic [DW-1:0]             cpu_rdata,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic                      req_write,
  output logic [ADDR_W-1:0]         req_addr,
  output logic [DW-1:0]             req_data,
  input  logic                      rsp_valid,
  input  logic [1:0]                rsp_kind,
  input  logic [ADDR_W-1:0]         rsp_addr,
  input  logic [DW-1:0]             rsp_word,
  input  logic [DW*(2**OFF_W)-1:0]  rsp_line
);
  localparam int WORDS = 2 ** OFF_W;
  localparam int SETS  = 2 ** IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  localparam logic [1:0] L_NONE = 2'd0, L_SHRD = 2'd1, L_TRAN = 2'd2;
  localparam logic [1:0] C_IDLE = 2'd0, C_REQ = 2'd1, C_WSH = 2'd2, C_WWR = 2'd3;
  localparam logic [1:0] K_SHREP = 2'd0, K_WREP = 2'd1, K_UPD = 2'd2;

  logic [1:0]       lst  [SETS];
  logic [TAG_W-1:0] ltag [SETS];
  logic [DW-1:0]    mem  [SETS*WORDS];
  logic [1:0]       ctl;
  logic             pend_hit;

  wire [IDX_W-1:0] c_idx = cpu_addr[OFF_W +: IDX_W];
  wire [OFF_W-1:0] c_off = cpu_addr[OFF_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  wire             c_hit = (lst[c_idx] == L_SHRD) && (ltag[c_idx] == c_tag);

  wire [IDX_W-1:0] r_idx = rsp_addr[OFF_W +: IDX_W];
  wire [OFF_W-1:0] r_off = rsp_addr[OFF_W-1:0];
  wire [TAG_W-1:0] r_tag = rsp_addr[ADDR_W-1 -: TAG_W];
  wire             r_hit = (lst[r_idx] == L_SHRD) && (ltag[r_idx] == r_tag);

  assign cpu_ready = (ctl == C_IDLE);
  wire accept = cpu_valid && cpu_ready;
  wire fill   = rsp_valid && (rsp_kind == K_SHREP) && (ctl == C_WSH);
  wire wrel   = rsp_valid && (rsp_kind == K_WREP) && (ctl == C_WWR);
  wire wordup = rsp_valid && (rsp_kind == K_WREP || rsp_kind == K_UPD) && r_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl        <= C_IDLE;
      req_valid  <= 1'b0;
      req_write  <= 1'b0;
      req_addr   <= '0;
      req_data   <= '0;
      pend_hit   <= 1'b0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
      for (int s = 0; s < SETS; s++) lst[s] <= L_NONE;
    end else begin
      cpu_rvalid <= 1'b0;
      if (ctl == C_REQ && req_ready) begin
        req_valid <= 1'b0;
        ctl <= !req_write ? C_WSH : (pend_hit ? C_WWR : C_IDLE);
      end
      if (accept) begin
        if (cpu_we) begin
          req_valid <= 1'b1;
          req_write <= 1'b1;
          req_addr  <= cpu_addr;
          req_data  <= cpu_wdata;
          pend_hit  <= c_hit;
          ctl       <= C_REQ;
        end else if (c_hit) begin
          cpu_rvalid <= 1'b1;
          cpu_rdata  <= mem[{c_idx, c_off}];
        end else begin
          lst[c_idx] <= L_TRAN;
          req_valid  <= 1'b1;
          req_write  <= 1'b0;
          req_addr   <= cpu_addr;
          req_data   <= '0;
          ctl        <= C_REQ;
        end
      end
      if (fill) begin
        lst[r_idx] <= L_SHRD;
        cpu_rvalid <= 1'b1;
        cpu_rdata  <= rsp_line[r_off*DW +: DW];
        ctl        <= C_IDLE;
      end
      if (wrel) ctl <= C_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !cpu_we && !c_hit) ltag[c_idx] <= c_tag;
    if (fill) begin
      for (int w = 0; w < WORDS; w++) mem[{r_idx, OFF_W'(w)}] <= rsp_line[w*DW +: DW];
    end else if (wordup) begin
      mem[{r_idx, r_off}] <= rsp_word;
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_data)); // R10
  AST_HIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cpu_we && c_hit |=> cpu_rvalid && !req_valid); // R5
  AST_MISS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cpu_we && !c_hit |=> req_valid && !req_write && !cpu_ready); // R4
  AST_STORE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl == C_WWR && !(rsp_valid && rsp_kind == K_WREP) |=> !cpu_ready); // R2
  AST_FILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl == C_WSH && rsp_valid && rsp_kind == K_SHREP |=> cpu_rvalid && cpu_ready); // R6
  AST_ABSENT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl == C_REQ && req_ready && req_write && !pend_hit |=> cpu_ready); // R3
endmodule

// File: tb/wu_cache_ctrl_bench.sv
module wu_cache_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_we = 0, req_ready = 0, rsp_valid = 0;
  logic [7:0] cpu_addr = 0, rsp_addr = 0;
  logic [15:0] cpu_wdata = 0, rsp_word = 0;
  logic [1:0] rsp_kind = 0;
  logic [63:0] rsp_line = 0;
  logic cpu_ready, cpu_rvalid, req_valid, req_write;
  logic [15:0] cpu_rdata, req_data;
  logic [7:0] req_addr;

  wu_cache_ctrl u_wu_cache_ctrl (
    .clk, .rst_n, .cpu_valid, .cpu_ready, .cpu_we, .cpu_addr, .cpu_wdata,
    .cpu_rvalid, .cpu_rdata, .req_valid, .req_ready, .req_write, .req_addr,
    .req_data, .rsp_valid, .rsp_kind, .rsp_addr, .rsp_word, .rsp_line);

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  logic [15:0] home [256];
  bit mpres [4];
  logic [3:0] mtag [4];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] line_of(logic [7:0] a);
    logic [63:0] l;
    for (int w = 0; w < 4; w++) l[w*16 +: 16] = home[{a[7:2], 2'(w)}];
    return l;
  endfunction

  task automatic send_rsp(logic [1:0] k, logic [7:0] a, logic [15:0] wd);
    rsp_valid = 1; rsp_kind = k; rsp_addr = a; rsp_word = wd; rsp_line = line_of(a);
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic do_op(bit we, logic [7:0] a, logic [15:0] d, bit inject);
    bit hit = mpres[a[3:2]] && mtag[a[3:2]] == a[7:4];
    chk(cpu_ready == 1, "R10 ready before op", cpu_ready, 1);
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_valid = 0;
    if (!we && hit) begin
      chk(cpu_rvalid && cpu_rdata == home[a], "R5 hit data", {cpu_rvalid, cpu_rdata}, {1'b1, home[a]});
      chk(!req_valid, "R5 hit sends nothing", req_valid, 0);
      return;
    end
    chk(req_valid && req_write == we && req_addr == a && req_data == (we ? d : 16'h0),
        we ? (hit ? "R2 write request" : "R3 write request") : "R4 share request",
        {req_valid, req_write, req_addr, req_data}, {1'b1, we, a, we ? d : 16'h0});
    chk(!cpu_ready, "R10 stall while pending", cpu_ready, 0);
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(req_valid && req_addr == a && req_write == we, "R10 request held", {req_valid, req_addr}, {1'b1, a});
    end
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    chk(!req_valid, "R10 request retired", req_valid, 0);
    if (we) begin
      home[a] = d;
      if (hit) begin
        chk(!cpu_ready, "R2 stall until reply", cpu_ready, 0);
        @(negedge clk);
        chk(!cpu_ready, "R2 still stalled", cpu_ready, 0);
        send_rsp(2'd1, a, d);
        chk(cpu_ready, "R2 released by reply", cpu_ready, 1);
      end else begin
        chk(cpu_ready, "R3 no stall", cpu_ready, 1);
      end
    end else begin
      chk(!cpu_ready, "R4 stall on miss", cpu_ready, 0);
      if (inject) send_rsp(2'd2, a, ~home[a]);
      send_rsp(2'd0, a, 16'h0);
      chk(cpu_rvalid && cpu_rdata == home[a] && cpu_ready, inject ? "R8 transient update ignored" : "R6 fill data",
          {cpu_ready, cpu_rvalid, cpu_rdata}, {2'b11, home[a]});
      mpres[a[3:2]] = 1; mtag[a[3:2]] = a[7:4];
    end
  endtask

  task automatic push_word(bit is_wrep, logic [7:0] a, logic [15:0] v, bit keep_home);
    send_rsp(is_wrep ? 2'd1 : 2'd2, a, v);
    if (keep_home) home[a] = v;
    chk(cpu_ready && !req_valid, is_wrep ? "R9 stray reply keeps ready" : "R8 update no stall",
        {cpu_ready, req_valid}, 2'b10);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    for (int a = 0; a < 256; a++) home[a] = 16'(a * 16'h0101) ^ 16'h5a5a;
    for (int s = 0; s < 4; s++) begin mpres[s] = 0; mtag[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_ready && !req_valid && !cpu_rvalid, "R1 reset outputs", {cpu_ready, req_valid, cpu_rvalid}, 3'b100);
    do_op(0, 8'h04, 0, 0);           // R1 first load misses
    do_op(0, 8'h05, 0, 0);           // R5 hit on same line
    do_op(1, 8'h06, 16'hbeef, 0);    // R2 store to held line
    do_op(0, 8'h06, 0, 0);           // R2 reply word in cache
    do_op(1, 8'h30, 16'h1234, 0);    // R3 store to absent line
    do_op(0, 8'h30, 0, 0);           // R3 then miss
    do_op(0, 8'h14, 0, 0);           // R7 evicts tag 0 at index 1
    do_op(0, 8'h04, 0, 0);           // R7 old address misses again
    push_word(0, 8'h07, 16'hc0de, 1); // R8 update on held line
    do_op(0, 8'h07, 0, 0);
    push_word(0, 8'h18, 16'hdead, 0); // R8 absent line ignored
    do_op(0, 8'h18, 0, 0);
    do_op(0, 8'h2c, 0, 1);           // R8 ignored while transient
    push_word(1, 8'h2d, 16'h7777, 1); // R9 stray reply
    do_op(0, 8'h2d, 0, 0);
    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 100;
      logic [7:0] a = 8'($urandom % 64);
      if (r < 45) do_op(0, a, 0, 0);
      else if (r < 80) do_op(1, a, 16'($urandom), 0);
      else push_word($urandom % 2 == 1, a, 16'($urandom), 1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule